// File: doc/BRIEF.md
# Programmable Wake and Watchdog Timer

This block counts a selectable delay period on a slow timebase and, at the end of each period, drives one of two event pulses. The clock is the timebase itself: every clock edge is one tick, nominally 32.768 kHz. A calibration pulse is issued a fixed time before each event. A host can use it to measure the true tick rate against its own clock.

The block has two modes. In wake mode it produces a wake pulse at the end of every period. In watchdog mode the host must acknowledge each period with a pulse on the acknowledge input, inside an allowed window. A period that closes with a valid acknowledgement produces a wake pulse. A period that closes without one produces an active-low reset pulse. The counter restarts at the first tick of every event pulse, so events repeat at a fixed rate. A power-good input holds the whole block idle while it is low.

All durations are set by two parameters: `TICKS_PER_SEC` (default 32768) and `CAL_TICKS` (default 512). Below, P is the length in ticks of the current period. The count is the number of ticks since the start of the last event pulse; it is 0 on that pulse's first tick.

Top module: `wake_watchdog_timer`

## Requirements
- R1: `periodSel` codes 0 to 7 select 1, 2, 4, 8, 10, 16, 32 and 64 seconds. P is that number times `TICKS_PER_SEC`. Two successive event pulses start exactly P ticks apart.
- R2: `periodSel` is sampled only when a period starts. A change in the middle of a period does not alter that period's length.
- R3: `calPulse` is high for exactly `CAL_TICKS` ticks in every period. It falls `CAL_TICKS/2` ticks before the next event pulse starts.
- R4: A wake event drives `wakePulse` high for exactly 2*`CAL_TICKS` ticks.
- R5: A reset event drives `resetPulseN` low for exactly `CAL_TICKS` ticks.
- R6: In watchdog mode (`watchdogMode`=1), a period that saw a valid acknowledgement ends in a wake event. A period that saw none ends in a reset event.
- R7: In wake mode (`watchdogMode`=0), every period ends in a wake event, whether or not an acknowledgement arrived.
- R8: `hostAck` passes through two synchronising flops, and its rising edge is recognised in the second cycle after `hostAck` is first sampled high. An edge is valid only when recognised at a count from 1 to P-5*`CAL_TICKS`. Edges recognised at count 0 or later than that window are ignored.
- R9: While `powerGood` is low, the count is held at zero. From the next tick on, `wakePulse` is low, `resetPulseN` is high and `calPulse` is low.
- R10: After `powerGood` rises, counting restarts from zero and no event pulse is issued at that start. The first event pulse starts P ticks later. An event pulse only ever starts in the tick after a period ends.
- R11: `wakePulse`, the low phase of `resetPulseN`, and `calPulse` are never active at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one edge per timebase tick |
| arstN | input | 1 | Asynchronous reset, active low |
| periodSel | input | 3 | Delay period code, 0 (shortest) to 7 (longest) |
| watchdogMode | input | 1 | 1 = watchdog mode, 0 = wake mode |
| powerGood | input | 1 | Low holds the timer idle |
| hostAck | input | 1 | Host acknowledgement (watchdog kick), asynchronous |
| wakePulse | output | 1 | Wake event pulse, active high |
| resetPulseN | output | 1 | Reset event pulse, active low |
| calPulse | output | 1 | Calibration pulse, active high |

## Verification
The hardest situations to reach are acknowledgements near the edges of the window: one recognised exactly on the last valid count, one a tick later, and one recognised on the first tick of an event pulse. The synchroniser delay separates the tick on which the host acts from the tick on which the edge counts. The bench therefore times each kick against the count held by its own reference model, launching it two ticks before the target count. It also launches a kick late in a period so that its edge lands on count 0 or count 1 of the next period.

// File: rtl/wwt_pkg.sv
package wwt_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_WAKE  = 2'd1,
    EV_RESET = 2'd2
  } evKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hold;
    logic restart;
  } dpCtrl_t;

  // decoded count state from datapath to control
  typedef struct packed {
    logic atEnd;
    logic ackEdge;
    logic inWindow;
    logic calSpan;
    logic wakeSpan;
    logic rstSpan;
  } dpStatus_t;

  function automatic int unsigned periodSeconds(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd4: return 10;
      3'd5: return 16;
      3'd6: return 32;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/wwt_datapath.sv
module wwt_datapath
  import wwt_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned CAL_TICKS     = 512
) (
  input  logic       clk,
  input  logic       arstN,
  input  logic [2:0] periodSel,
  input  logic       hostAck,
  input  dpCtrl_t    ctrl,
  output dpStatus_t  status
);

  localparam int unsigned LONGEST    = 64 * TICKS_PER_SEC;
  localparam int unsigned CNT_W      = $clog2(LONGEST + 1);
  localparam int unsigned GAP_TICKS  = CAL_TICKS / 2;
  localparam int unsigned ACK_MARGIN = 5 * CAL_TICKS;
  localparam int unsigned WAKE_TICKS = 2 * CAL_TICKS;

  typedef logic [CNT_W-1:0] cnt_t;

  cnt_t tickCnt;
  cnt_t periodLen;
  cnt_t nextLen;
  logic [2:0] ackPipe;

  assign nextLen = cnt_t'(periodSeconds(periodSel) * TICKS_PER_SEC);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      tickCnt   <= '0;
      periodLen <= cnt_t'(TICKS_PER_SEC);
    end else if (ctrl.hold || ctrl.restart) begin
      tickCnt   <= '0;
      periodLen <= nextLen;
    end else begin
      tickCnt   <= tickCnt + cnt_t'(1);
    end
  end

  // two synchronising stages plus one for edge detection
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) ackPipe <= '0;
    else        ackPipe <= {ackPipe[1:0], hostAck};
  end

  assign status.ackEdge  = ackPipe[1] & ~ackPipe[2];
  assign status.atEnd    = (tickCnt == periodLen - cnt_t'(1));
  assign status.inWindow = (tickCnt >= cnt_t'(1)) &&
                           (tickCnt <= periodLen - cnt_t'(ACK_MARGIN));
  assign status.calSpan  = (tickCnt >= periodLen - cnt_t'(GAP_TICKS + CAL_TICKS)) &&
                           (tickCnt <  periodLen - cnt_t'(GAP_TICKS));
  assign status.wakeSpan = (tickCnt < cnt_t'(WAKE_TICKS));
  assign status.rstSpan  = (tickCnt < cnt_t'(CAL_TICKS));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!arstN)
    tickCnt < periodLen);

  // R2
  len_hold_chk: assert property (@(posedge clk) disable iff (!arstN)
    !(ctrl.hold || ctrl.restart) |=> $stable(periodLen));

endmodule

// File: rtl/wwt_control.sv
module wwt_control
  import wwt_pkg::*;
(
  input  logic      clk,
  input  logic      arstN,
  input  logic      powerGood,
  input  logic      watchdogMode,
  input  dpStatus_t status,
  output dpCtrl_t   ctrl,
  output logic      wakePulse,
  output logic      resetPulseN,
  output logic      calPulse
);

  evKind_e evKind;
  logic    ackSeen;
  logic    ackHit;

  assign ctrl.hold    = !powerGood;
  assign ctrl.restart = powerGood && status.atEnd;
  assign ackHit       = status.ackEdge && status.inWindow;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      evKind  <= EV_NONE;
      ackSeen <= 1'b0;
    end else if (ctrl.hold) begin
      evKind  <= EV_NONE;
      ackSeen <= 1'b0;
    end else if (ctrl.restart) begin
      evKind  <= (!watchdogMode || ackSeen) ? EV_WAKE : EV_RESET;
      ackSeen <= 1'b0;
    end else begin
      ackSeen <= ackSeen || ackHit;
    end
  end

  assign wakePulse   = (evKind == EV_WAKE) && status.wakeSpan;
  assign resetPulseN = !((evKind == EV_RESET) && status.rstSpan);
  assign calPulse    = status.calSpan;

  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!arstN)
    !powerGood |=> (!wakePulse && resetPulseN && !calPulse));

  // R7
  wake_mode_chk: assert property (@(posedge clk) disable iff (!arstN)
    (!watchdogMode && ctrl.restart) |=> (evKind == EV_WAKE));

  // R11
  excl_chk: assert property (@(posedge clk) disable iff (!arstN)
    $countones({wakePulse, !resetPulseN, calPulse}) <= 1);

  // R10
  event_start_chk: assert property (@(posedge clk) disable iff (!arstN)
    ($rose(wakePulse) || $fell(resetPulseN)) |-> $past(ctrl.restart));

endmodule

// File: rtl/wake_watchdog_timer.sv
module wake_watchdog_timer
  import wwt_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned CAL_TICKS     = 512
) (
  input  logic       clk,
  input  logic       arstN,
  input  logic [2:0] periodSel,
  input  logic       watchdogMode,
  input  logic       powerGood,
  input  logic       hostAck,
  output logic       wakePulse,
  output logic       resetPulseN,
  output logic       calPulse
);

  dpCtrl_t   dpCtrl;
  dpStatus_t dpStatus;

  wwt_datapath #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .CAL_TICKS    (CAL_TICKS)
  ) datapath_i (
    .clk      (clk),
    .arstN    (arstN),
    .periodSel(periodSel),
    .hostAck  (hostAck),
    .ctrl     (dpCtrl),
    .status   (dpStatus)
  );

  wwt_control control_i (
    .clk         (clk),
    .arstN       (arstN),
    .powerGood   (powerGood),
    .watchdogMode(watchdogMode),
    .status      (dpStatus),
    .ctrl        (dpCtrl),
    .wakePulse   (wakePulse),
    .resetPulseN (resetPulseN),
    .calPulse    (calPulse)
  );

endmodule

// File: tb/wake_watchdog_timer_tb_top.sv
module wake_watchdog_timer_tb_top;

  localparam int TPS = 64;
  localparam int CAL = 8;
  localparam int GAP = CAL / 2;

  logic       clk = 1'b0;
  logic       arstN = 1'b0;
  logic [2:0] periodSel = 3'd0;
  logic       watchdogMode = 1'b1;
  logic       powerGood = 1'b0;
  logic       hostAck = 1'b0;
  logic       wakePulse;
  logic       resetPulseN;
  logic       calPulse;

  always #5 clk = ~clk;

  wake_watchdog_timer #(.TICKS_PER_SEC(TPS), .CAL_TICKS(CAL)) dut_i (
    .clk(clk), .arstN(arstN), .periodSel(periodSel), .watchdogMode(watchdogMode),
    .powerGood(powerGood), .hostAck(hostAck),
    .wakePulse(wakePulse), .resetPulseN(resetPulseN), .calPulse(calPulse)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int secsTab[8] = '{1, 2, 4, 8, 10, 16, 32, 64};

  // reference model: kind 0 none, 1 wake, 2 reset
  int mCnt = 0, mLen = TPS, mKind = 0, mSeen = 0, mPrevLen = TPS;
  int a1 = 0, a2 = 0, a3 = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int edgeNow;
    cyc++;
    edgeNow = (a2 == 1 && a3 == 0) ? 1 : 0;
    if (!arstN) begin
      mCnt = 0; mLen = TPS; mKind = 0; mSeen = 0;
      a1 = 0; a2 = 0; a3 = 0;
    end else begin
      if (!powerGood) begin
        mCnt = 0; mLen = secsTab[periodSel] * TPS; mKind = 0; mSeen = 0;
      end else if (mCnt == mLen - 1) begin
        mPrevLen = mLen;
        mKind = (!watchdogMode || mSeen != 0) ? 1 : 2;
        mSeen = 0;
        mCnt = 0;
        mLen = secsTab[periodSel] * TPS;
      end else begin
        if (edgeNow != 0 && mCnt >= 1 && mCnt <= mLen - 5 * CAL) mSeen = 1;
        mCnt++;
      end
      a3 = a2; a2 = a1; a1 = hostAck;
    end
  end

  int wRun = 0, rRun = 0, cRun = 0, calFall = 0, lastRise = 0;
  bit riseValid = 0, prevEv = 0, prevCal = 0;

  always @(negedge clk) begin
    bit expW, expR, expC, ev;
    if (arstN) begin
      expW = (mKind == 1 && mCnt < 2 * CAL);
      expR = !(mKind == 2 && mCnt < CAL);
      expC = (mCnt >= mLen - GAP - CAL && mCnt < mLen - GAP);
      chk(wakePulse == expW, "R4/R6 wakePulse vs model", int'(wakePulse), int'(expW));
      chk(resetPulseN == expR, "R5/R6 resetPulseN vs model", int'(resetPulseN), int'(expR));
      chk(calPulse == expC, "R3 calPulse vs model", int'(calPulse), int'(expC));
      chk((int'(wakePulse) + int'(!resetPulseN) + int'(calPulse)) <= 1, "R11 exclusive",
          int'(wakePulse) + int'(!resetPulseN) + int'(calPulse), 1);
      if (wakePulse) wRun++;
      else begin
        if (wRun > 0) chk(wRun == 2 * CAL, "R4 wake width", wRun, 2 * CAL);
        wRun = 0;
      end
      if (!resetPulseN) rRun++;
      else begin
        if (rRun > 0) chk(rRun == CAL, "R5 reset width", rRun, CAL);
        rRun = 0;
      end
      if (calPulse) cRun++;
      else begin
        if (cRun > 0) chk(cRun == CAL, "R3 cal width", cRun, CAL);
        cRun = 0;
      end
      if (prevCal && !calPulse) calFall = cyc;
      ev = wakePulse || !resetPulseN;
      if (ev && !prevEv) begin
        chk(cyc - calFall == GAP, "R3 cal-to-event gap", cyc - calFall, GAP);
        if (riseValid) chk(cyc - lastRise == mPrevLen, "R1 event spacing", cyc - lastRise, mPrevLen);
        lastRise = cyc;
        riseValid = 1;
      end
      if (mKind == 0) riseValid = 0;
      prevEv = ev;
      prevCal = calPulse;
    end
  end

  task automatic waitCnt(input int c);
    do @(negedge clk); while (mCnt != c);
  endtask

  task automatic kickAt(input int c);
    waitCnt(c);
    hostAck = 1'b1;
    @(negedge clk);
    @(negedge clk);
    hostAck = 1'b0;
  endtask

  task automatic waitEvent(output bit isWake);
    do @(negedge clk); while (wakePulse || !resetPulseN);
    do @(negedge clk); while (!(wakePulse || !resetPulseN));
    isWake = wakePulse;
  endtask

  always @(posedge clk) begin
    if (cyc == 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit w;
    int t0;
    repeat (3) @(negedge clk);
    arstN = 1'b1;
    repeat (10) begin
      @(negedge clk);
      chk(!wakePulse && resetPulseN && !calPulse, "R9 idle after reset", int'(wakePulse), 0);
    end

    // R10: first period after power good, no ack -> R6 reset event
    powerGood = 1'b1;
    t0 = cyc;
    waitEvent(w);
    chk(cyc - t0 == TPS, "R10 first event delay", cyc - t0, TPS);
    chk(!w, "R6 no ack gives reset", int'(w), 0);

    kickAt(5);
    waitEvent(w);
    chk(w, "R6 ack gives wake", int'(w), 1);

    kickAt(22);            // edge recognised at count 24 = P-5*CAL
    waitEvent(w);
    chk(w, "R8 last valid count", int'(w), 1);

    kickAt(23);            // edge at count 25, too late
    waitEvent(w);
    chk(!w, "R8 late ack ignored", int'(w), 0);

    kickAt(63);            // edge lands on count 1 of next period
    chk(!resetPulseN, "R6 reset event in progress", int'(resetPulseN), 0);
    waitEvent(w);
    chk(w, "R8 first valid count", int'(w), 1);

    kickAt(62);            // this period unacknowledged; edge lands on count 0
    chk(!resetPulseN, "R6 reset event in progress", int'(resetPulseN), 0);
    waitEvent(w);
    chk(!w, "R8 ack on event tick ignored", int'(w), 0);

    // R7: wake mode without acknowledgement
    watchdogMode = 1'b0;
    waitEvent(w);
    waitEvent(w);
    chk(w, "R7 wake mode event", int'(w), 1);
    waitEvent(w);
    chk(w, "R7 wake mode event", int'(w), 1);

    // R2: mid-period select change has no effect
    waitCnt(20);
    periodSel = 3'd4;
    waitCnt(40);
    periodSel = 3'd0;
    waitEvent(w);
    t0 = cyc;
    waitEvent(w);
    chk(cyc - t0 == TPS, "R2 mid-period select ignored", cyc - t0, TPS);

    // R1: every code
    for (int k = 0; k < 8; k++) begin
      periodSel = 3'(k);
      waitEvent(w);
      t0 = cyc;
      waitEvent(w);
      chk(cyc - t0 == secsTab[k] * TPS, "R1 period length", cyc - t0, secsTab[k] * TPS);
    end

    // R9 / R10: power good drop mid period
    periodSel = 3'd4;
    waitEvent(w);
    waitEvent(w);
    waitCnt(200);
    powerGood = 1'b0;
    repeat (20) begin
      @(negedge clk);
      chk(!wakePulse && resetPulseN && !calPulse, "R9 held while power low", int'(calPulse), 0);
    end
    powerGood = 1'b1;
    t0 = cyc;
    repeat (2 * CAL) begin
      @(negedge clk);
      chk(!wakePulse && resetPulseN, "R10 no pulse at restart", int'(wakePulse), 0);
    end
    waitEvent(w);
    chk(cyc - t0 == 10 * TPS, "R10 restart from zero", cyc - t0, 10 * TPS);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule